// File: doc/BRIEF.md
# DMA Channel Bus-Mode Transfer Sequencer

This block runs one DMA channel on a bus shared with other masters. After a start pulse it captures a configuration: the bus mode, the unit size, the request source, the unit count and the source and destination base addresses with their increment enables. For each unit it asks an arbiter for the bus. It then issues a read cycle at the source address, holds the returned data, and writes that data at the destination address in the next cycle. After each unit it decides whether to keep the bus, give it back, or finish.

In cycle-steal mode the bus is handed back after every unit and requested again for the next one. In burst mode the bus is kept from unit to unit. It is given up early only if the external active-low request line is found inactive at a unit boundary. A burst request from a serial-port or ADC source is not honoured: the channel runs in cycle-steal mode and raises a configuration-error flag.

The controller has five states. IDLE waits for start (start→WAIT, or start with a zero count→IDLE with done set). WAIT holds the bus request low until a request is present (WAIT→ARB). ARB drives the bus request and waits for grant (ARB→RD). RD is the source read (RD→WR). WR is the destination write. From WR the controller goes to IDLE on the last unit, back to RD to keep the bus in burst mode, or to WAIT to release the bus.

Top module: `dma_busmode_seq`

## Requirements
- R1: A start pulse in IDLE captures all configuration inputs. A start pulse in any other state has no effect on the run. A start with a zero count sets done in the next cycle and never requests the bus.
- R2: The bus request is raised only once a request is present. No read begins before bus_gnt is seen high. While grant is withheld, bus_req stays high and no cycle is issued.
- R3: Each unit is one read cycle (bus_rd) at the source address, followed in the next cycle by one write cycle (bus_wr) at the destination address. bus_wdata equals the data returned by that read.
- R4: In cycle-steal mode, bus_req is low in the cycle after every write, and the bus is requested anew for each unit.
- R5: In burst mode with a request present at every boundary, all units run back to back under one continuous bus request.
- R6: In burst mode with an external request (req_src 0), if dreq_n is high at a unit boundary, the current unit finishes and the bus is released. No further unit starts until dreq_n is low again.
- R7: With req_src 2 (serial port) or 3 (ADC) and burst selected, the channel behaves as in cycle-steal mode and cfg_err is high until the next accepted start. For any other setting, cfg_err is low.
- R8: unit_sel codes 0, 1, 2, 3 select units of 1, 2, 4 and 16 bytes. After each unit, an address whose increment enable is set advances by that many bytes, and an address whose enable is clear stays fixed.
- R9: The channel transfers exactly xfer_count units. done rises in the cycle after the last write, busy falls at the same time, and done then holds until the next accepted start.
- R10: After reset: bus_req, bus_rd, bus_wr, busy, done and cfg_err are all low.
- R11: Request source codes are 0 external (dreq_n active low, level sensed), 1 auto (always requesting), 2 serial and 3 ADC (both using dreq_n). For every source except auto, a unit is accepted only while dreq_n is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in IDLE only) |
| mode_burst | input | 1 | 1 = burst, 0 = cycle-steal |
| unit_sel | input | 2 | Unit size code: 0=1 B, 1=2 B, 2=4 B, 3=16 B |
| req_src | input | 2 | Request source: 0 external, 1 auto, 2 serial, 3 ADC |
| xfer_count | input | CW | Number of units to move |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| src_inc | input | 1 | Step source address after each unit |
| dst_inc | input | 1 | Step destination address after each unit |
| dreq_n | input | 1 | Active-low level transfer request |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_rdata | input | DW | Read data from the bus |
| bus_req | output | 1 | Bus ownership request |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_addr | output | AW | Address of the current cycle |
| bus_wdata | output | DW | Write data (held read data) |
| bus_unit | output | 2 | Unit size code of the current cycle |
| busy | output | 1 | Channel running |
| done | output | 1 | Run complete |
| cfg_err | output | 1 | Burst refused for a peripheral source |

## Verification
A wrong state register shows up at the bus strobes within one or two cycles. Examples are a read with no grant, a write without a read before it, or a bus request that stays high after a cycle-steal write. A miscounted remaining-unit counter shows up only at the end of a run, as a wrong number of write strobes or a done flag that is early or late. The bench therefore counts reads, writes and bus tenures for every run. A bad address step or a lost holding register shows up on the very next strobe, so every read and write address and every write data word is compared as it happens.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ARB,
        ST_RD,
        ST_WR
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_EXT    = 2'd0,
        SRC_AUTO   = 2'd1,
        SRC_SERIAL = 2'd2,
        SRC_ADC    = 2'd3
    } req_src_t;

    // Bytes moved per unit for a size code
    function automatic logic [4:0] unit_bytes(input logic [1:0] code);
        unit_bytes = (code == 2'd3) ? 5'd16 : (5'd1 << code);
    endfunction

endpackage

// File: rtl/dma_unit_ctr.sv
module dma_unit_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          is_last
);
    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= load_val;
        else if (dec && remain_q != '0)
            remain_q <= remain_q - CW'(1);
    end

    assign is_last = (remain_q == CW'(1));
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_en_in,
    input  logic          step,
    input  logic [1:0]    unit,
    output logic [AW-1:0] addr
);
    logic inc_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            inc_en_q <= 1'b0;
        end else if (load) begin
            addr     <= load_val;
            inc_en_q <= inc_en_in;
        end else if (step && inc_en_q) begin
            addr <= addr + AW'(unit_bytes(unit));
        end
    end
endmodule

// File: rtl/dma_busmode_seq.sv
module dma_busmode_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_burst,
    input  logic [1:0]    unit_sel,
    input  logic [1:0]    req_src,
    input  logic [CW-1:0] xfer_count,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic          src_inc,
    input  logic          dst_inc,
    input  logic          dreq_n,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic [1:0]    bus_unit,
    output logic          busy,
    output logic          done,
    output logic          cfg_err
);
    localparam int NPTR = 2; // 0 = source, 1 = destination

    seq_state_t state_q, state_d;
    req_src_t   src_q;
    logic       cfg_burst_eff;
    logic [1:0] unit_q;
    logic [DW-1:0] hold_q;
    logic       is_last;
    logic       accept, unit_end, req_ok, periph;

    logic [AW-1:0] ptr_base [NPTR];
    logic          ptr_inc  [NPTR];
    logic [AW-1:0] ptr_addr [NPTR];

    assign accept   = (state_q == ST_IDLE) && start;
    assign unit_end = (state_q == ST_WR);
    assign periph   = (req_src == SRC_SERIAL) || (req_src == SRC_ADC);
    assign req_ok   = (src_q == SRC_AUTO) || !dreq_n;

    assign ptr_base[0] = src_base;
    assign ptr_base[1] = dst_base;
    assign ptr_inc[0]  = src_inc;
    assign ptr_inc[1]  = dst_inc;

    generate
        for (genvar p = 0; p < NPTR; p++) begin : g_ptr
            dma_addr_step #(.AW(AW)) u_step (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (accept),
                .load_val  (ptr_base[p]),
                .inc_en_in (ptr_inc[p]),
                .step      (unit_end),
                .unit      (unit_q),
                .addr      (ptr_addr[p])
            );
        end
    endgenerate

    dma_unit_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (xfer_count),
        .dec      (unit_end),
        .is_last  (is_last)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (xfer_count == '0) ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (req_ok) state_d = ST_ARB;
            ST_ARB:  if (bus_gnt) state_d = ST_RD;
            ST_RD:   state_d = ST_WR;
            ST_WR: begin
                if (is_last)                     state_d = ST_IDLE;
                else if (cfg_burst_eff && req_ok) state_d = ST_RD;
                else                             state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            src_q         <= SRC_EXT;
            unit_q        <= 2'd0;
            cfg_burst_eff <= 1'b0;
            cfg_err       <= 1'b0;
            done          <= 1'b0;
            hold_q        <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                src_q         <= req_src_t'(req_src);
                unit_q        <= unit_sel;
                cfg_burst_eff <= mode_burst && !periph;
                cfg_err       <= mode_burst && periph;
                done          <= (xfer_count == '0);
            end else if (unit_end && is_last) begin
                done <= 1'b1;
            end
            if (state_q == ST_RD)
                hold_q <= bus_rdata;
        end
    end

    // Outputs decoded from state
    always_comb begin
        bus_req   = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_WAIT: ;
            ST_ARB:  bus_req = 1'b1;
            ST_RD: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = ptr_addr[0];
            end
            ST_WR: begin
                bus_req  = 1'b1;
                bus_wr   = 1'b1;
                bus_addr = ptr_addr[1];
            end
            default: busy = 1'b0;
        endcase
    end

    assign bus_wdata = hold_q;
    assign bus_unit  = unit_q;

endmodule

// File: rtl/dma_busmode_seq_chk.sv
module dma_busmode_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] bus_wdata,
    input logic          busy,
    input logic          done,
    input logic          burst_eff
);
    // R2
    rd_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_req && bus_gnt));

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);

    // R3
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));

    // R3
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_wdata == $past(bus_rdata)));

    // R4
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !burst_eff) |=> !bus_req);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bus_req));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
endmodule

bind dma_busmode_seq dma_busmode_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done),
    .burst_eff (cfg_burst_eff)
);

// File: tb/dma_busmode_seq_tb.sv
module dma_busmode_seq_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        bit        burst;
        bit [1:0]  unit;
        bit [1:0]  src;
        bit [15:0] cnt;
        bit        inc_s;
        bit        inc_d;
        bit [7:0]  tenures;
        bit        err;
    } vec_t;

    // dreq_n held low for every row
    localparam vec_t VEC [8] = '{
        '{1'b0, 2'd0, 2'd0, 16'd3, 1'b1, 1'b1, 8'd3, 1'b0}, // steal, 1 B, ext
        '{1'b1, 2'd1, 2'd0, 16'd4, 1'b1, 1'b1, 8'd1, 1'b0}, // burst, 2 B, ext
        '{1'b1, 2'd2, 2'd1, 16'd2, 1'b1, 1'b1, 8'd1, 1'b0}, // burst, 4 B, auto
        '{1'b1, 2'd3, 2'd0, 16'd3, 1'b1, 1'b0, 8'd1, 1'b0}, // burst, 16 B, dst fixed
        '{1'b1, 2'd0, 2'd2, 16'd3, 1'b1, 1'b1, 8'd3, 1'b1}, // burst refused, serial
        '{1'b1, 2'd2, 2'd3, 16'd2, 1'b0, 1'b1, 8'd2, 1'b1}, // burst refused, ADC
        '{1'b0, 2'd3, 2'd1, 16'd2, 1'b0, 1'b0, 8'd2, 1'b0}, // steal, 16 B, auto
        '{1'b0, 2'd1, 2'd2, 16'd1, 1'b1, 1'b1, 8'd1, 1'b0}  // steal, serial
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_burst = 1'b0;
    logic [1:0] unit_sel = 2'd0, req_src = 2'd0;
    logic [CW-1:0] xfer_count = '0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic src_inc = 1'b0, dst_inc = 1'b0, dreq_n = 1'b1, bus_gnt = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic bus_req, bus_rd, bus_wr, busy, done, cfg_err;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [1:0] bus_unit;

    int n_chk = 0, n_err = 0;
    int n_rd = 0, n_wr = 0, n_ten = 0;
    logic gnt_en = 1'b1, req_prev = 1'b0;
    logic [AW-1:0] exp_src, exp_dst;
    int step_s, step_d;
    logic [DW-1:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_busmode_seq #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_burst(mode_burst),
        .unit_sel(unit_sel), .req_src(req_src), .xfer_count(xfer_count),
        .src_base(src_base), .dst_base(dst_base), .src_inc(src_inc),
        .dst_inc(dst_inc), .dreq_n(dreq_n), .bus_gnt(bus_gnt),
        .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_unit(bus_unit), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    assign bus_rdata = mem_val(bus_addr);

    function automatic int unit_size(input logic [1:0] u);
        return (u == 2'd3) ? 16 : (1 << u);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Simple arbiter: grant follows request half a cycle later
    always @(negedge clk) bus_gnt <= gnt_en & bus_req;

    // Bus monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !req_prev) n_ten++;
            req_prev = bus_req;
            if (bus_rd) begin
                chk("R8 read address", bus_addr, exp_src);
                last_rd = mem_val(bus_addr);
                exp_src = exp_src + AW'(step_s);
                n_rd++;
            end
            if (bus_wr) begin
                chk("R8 write address", bus_addr, exp_dst);
                chk("R3 write data", bus_wdata, last_rd);
                exp_dst = exp_dst + AW'(step_d);
                n_wr++;
            end
        end
    end

    task automatic kick(input logic b, input logic [1:0] u, input logic [1:0] s,
                        input logic [CW-1:0] c, input logic is, input logic id,
                        input logic [AW-1:0] bs, input logic [AW-1:0] bd);
        @(negedge clk);
        mode_burst = b; unit_sel = u; req_src = s; xfer_count = c;
        src_inc = is; dst_inc = id; src_base = bs; dst_base = bd;
        exp_src = bs; exp_dst = bd;
        step_s = is ? unit_size(u) : 0;
        step_d = id ? unit_size(u) : 0;
        n_rd = 0; n_wr = 0; n_ten = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (done && !busy) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        chk("R10 bus_req", bus_req, 0);
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 cfg_err", cfg_err, 0);
        chk("R10 strobes", {bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        dreq_n = 1'b0;
        @(negedge clk);

        // Table walk: R3 R4 R5 R7 R8 R9 R11
        for (int v = 0; v < 8; v++) begin
            kick(VEC[v].burst, VEC[v].unit, VEC[v].src, VEC[v].cnt,
                 VEC[v].inc_s, VEC[v].inc_d, 32'h1000 * (v + 1), 32'h8000 + 32'h100 * v);
            chk("R7 cfg_err", cfg_err, VEC[v].err);
            wait_done();
            chk("R9 read count", n_rd, VEC[v].cnt);
            chk("R9 write count", n_wr, VEC[v].cnt);
            chk("R4 R5 bus tenures", n_ten, VEC[v].tenures);
            chk("R9 done", done, 1);
            chk("R9 busy low", busy, 0);
            chk("R8 final dst", exp_dst,
                32'h8000 + 32'h100 * v + (VEC[v].inc_d ? VEC[v].cnt * unit_size(VEC[v].unit) : 0));
        end

        // R9: done holds while idle
        repeat (3) @(negedge clk);
        chk("R9 done held", done, 1);

        // R1: zero count finishes without the bus
        kick(1'b0, 2'd0, 2'd1, '0, 1'b1, 1'b1, 32'h40, 32'h80);
        chk("R1 zero-count done", done, 1);
        chk("R1 zero-count busy", busy, 0);
        repeat (3) @(negedge clk);
        chk("R1 zero-count no request", n_ten, 0);

        // R1: start while running is ignored
        kick(1'b0, 2'd2, 2'd0, 16'd2, 1'b1, 1'b1, 32'h2000, 32'h3000);
        xfer_count = 16'd9; src_base = 32'hFFF0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R1 busy start ignored", n_wr, 2);

        // R2: grant withheld
        gnt_en = 1'b0;
        kick(1'b1, 2'd1, 2'd1, 16'd1, 1'b1, 1'b1, 32'h500, 32'h600);
        repeat (4) @(negedge clk);
        chk("R2 request held", bus_req, 1);
        chk("R2 no read before grant", n_rd, 0);
        gnt_en = 1'b1;
        wait_done();
        chk("R2 unit after grant", n_wr, 1);

        // R11: external request high blocks the first unit
        dreq_n = 1'b1;
        kick(1'b0, 2'd0, 2'd0, 16'd1, 1'b1, 1'b1, 32'h700, 32'h900);
        repeat (4) @(negedge clk);
        chk("R11 no request while dreq high", bus_req, 0);
        chk("R11 still busy", busy, 1);
        dreq_n = 1'b0;
        wait_done();
        chk("R11 unit after dreq low", n_wr, 1);

        // R6: burst with request dropped mid-run
        kick(1'b1, 2'd2, 2'd0, 16'd5, 1'b1, 1'b1, 32'hA000, 32'hB000);
        for (int k = 0; k < 2; ) begin
            @(negedge clk);
            if (bus_rd) k++;
        end
        dreq_n = 1'b1;
        @(negedge clk);
        chk("R6 accepted unit finishes", bus_wr, 1);
        @(negedge clk);
        chk("R6 bus released", bus_req, 0);
        chk("R6 not done", done, 0);
        repeat (4) @(negedge clk);
        chk("R6 no unit while dreq high", n_rd, 2);
        dreq_n = 1'b0;
        wait_done();
        chk("R6 total units", n_wr, 5);
        chk("R6 two tenures", n_ten, 2);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule